// File: doc/BRIEF.md
# Clear-on-read interrupt status register

This block collects interrupt-worthy events into one status word and drives an active-low interrupt line toward a host. The low part of the word holds one bit for each of four bus branches. Each of these bits reports a transmit error on its branch, which covers wire-to-wire, wire-to-ground and wire-to-supply faults. The high part holds four event bits: power-on, wake-up, serial-interface error and host-command error.

The host reads the word over a serial link framed by an active-low chip select. A small frame tracker follows each frame. It notes whether the frame addressed the status word and whether a serial error was flagged during it. When a clean frame that addressed the word closes, the tracker issues a one-cycle clear. That clear resets only the four event bits. The branch bits follow their fault sources and are not affected by reads.

Frame tracker states: `FR_IDLE` (chip select high), `FR_OTHER` (frame open, status word not yet addressed), `FR_STATUS` (frame open, status word addressed), `FR_FAULT` (frame open, serial error seen). Transitions while chip select is low: `FR_IDLE` goes to `FR_FAULT` on a serial error, otherwise to `FR_STATUS` when the select input is high, otherwise to `FR_OTHER`. `FR_OTHER` goes to `FR_FAULT` on a serial error, or to `FR_STATUS` when the select input is high. `FR_STATUS` goes to `FR_FAULT` on a serial error. Chip select sampled high returns every state to `FR_IDLE`. The clear fires only on the `FR_STATUS` to `FR_IDLE` step, and only when no serial error is present in that same cycle.

Top module: `irq_status_reg`

## Requirements
- R1: While reset is applied, and after it is released, `status` reads 0x10 (only the power-on bit, bit 4, set) and `irq_n` is low.
- R2: Branch bit i (bits 3..0) equals `branch_err[i]` as sampled at the previous clock edge. Reads never clear it.
- R3: One cycle after its event input is sampled high, the matching bit is set: `por_evt` sets bit 4, `wake_evt` sets bit 5, `spi_err` sets bit 6 and `cmd_err` sets bit 7.
- R4: `irq_n` is low in every cycle in which any status bit is set, and high only when the whole word is zero.
- R5: Suppose `csn` is sampled low with `reg_sel` high in at least one cycle of a frame, and the frame then ends with `csn` sampled high. If no `spi_err` was sampled in the frame, bits 7..4 are zero in the following cycle.
- R6: If `spi_err` is sampled high in any cycle of a frame, including the cycle in which `csn` is sampled high, that frame clears nothing.
- R7: A frame in which `reg_sel` is never sampled high while `csn` is low clears nothing.
- R8: If an event input is high in the same cycle as a clear, its bit stays set.
- R9: In any cycle in which `csn` is sampled low, no bit among 7..4 goes from one to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| branch_err | input | 4 | Per-branch transmit error level |
| por_evt | input | 1 | Power-on event pulse |
| wake_evt | input | 1 | Wake-up event pulse |
| cmd_err | input | 1 | Host-command error pulse |
| csn | input | 1 | Serial chip select, active low, synchronous to clk |
| reg_sel | input | 1 | Current frame addresses the status word |
| spi_err | input | 1 | Serial error flagged in the current frame |
| status | output | 8 | Status word: bits 3..0 branches, 4 power-on, 5 wake-up, 6 serial error, 7 host-command error |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The properties take `csn`, `reg_sel`, `spi_err` and the event inputs to be synchronous to `clk` and stable around its rising edge. They also assume a frame is delimited only by `csn`, so a chip-select level held across an edge is never a new frame. The bench changes every input at the falling edge, so each value is seen by exactly one rising edge. Random frames of varied length carry serial errors and select pulses at random points, including the closing cycle. Directed frames cover the clean read, the faulted read, the unaddressed frame and the event that coincides with a clear.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int unsigned EVT_COUNT = 4;

    // position of each auto-clearing event inside the event field
    localparam int unsigned EVT_PWON = 0;
    localparam int unsigned EVT_WAKE = 1;
    localparam int unsigned EVT_SPI  = 2;
    localparam int unsigned EVT_CMD  = 3;

    // the power-on event is reported out of reset
    localparam logic [EVT_COUNT-1:0] EVT_RESET_VAL = 4'b0001;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_OTHER  = 2'd1,
        FR_STATUS = 2'd2,
        FR_FAULT  = 2'd3
    } frame_state_e;

endpackage

// File: rtl/irq_frame_fsm.sv
module irq_frame_fsm
    import irq_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic reg_sel,
    input  logic spi_err,
    output logic clr_pulse
);

    frame_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE: begin
                if (!csn) begin
                    if (spi_err)      state_d = FR_FAULT;
                    else if (reg_sel) state_d = FR_STATUS;
                    else              state_d = FR_OTHER;
                end
            end
            FR_OTHER: begin
                if (csn)          state_d = FR_IDLE;
                else if (spi_err) state_d = FR_FAULT;
                else if (reg_sel) state_d = FR_STATUS;
            end
            FR_STATUS: begin
                if (csn)          state_d = FR_IDLE;
                else if (spi_err) state_d = FR_FAULT;
            end
            FR_FAULT: begin
                if (csn)          state_d = FR_IDLE;
            end
            default: state_d = FR_IDLE;
        endcase
    end

    always_comb begin
        clr_pulse = 1'b0;
        unique case (state_q)
            FR_STATUS: clr_pulse = csn && !spi_err;
            FR_IDLE, FR_OTHER, FR_FAULT: clr_pulse = 1'b0;
            default: clr_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits
    import irq_status_pkg::*;
#(
    parameter int unsigned NUM_BRANCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BRANCH-1:0] branch_err,
    input  logic [EVT_COUNT-1:0]  evt,
    input  logic                  clr_pulse,
    output logic [NUM_BRANCH-1:0] branch_q,
    output logic [EVT_COUNT-1:0]  evt_q
);

    for (genvar b = 0; b < NUM_BRANCH; b++) begin : g_branch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                branch_q[b] <= 1'b0;
            end else begin
                branch_q[b] <= branch_err[b];
            end
        end
    end

    for (genvar e = 0; e < EVT_COUNT; e++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                evt_q[e] <= EVT_RESET_VAL[e];
            end else begin
                // a new event outranks a clear in the same cycle
                evt_q[e] <= evt[e] | (evt_q[e] & ~clr_pulse);
            end
        end
    end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_status_pkg::*;
#(
    parameter int unsigned NUM_BRANCH = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BRANCH-1:0]           branch_err,
    input  logic                            por_evt,
    input  logic                            wake_evt,
    input  logic                            cmd_err,
    input  logic                            csn,
    input  logic                            reg_sel,
    input  logic                            spi_err,
    output logic [NUM_BRANCH+EVT_COUNT-1:0] status,
    output logic                            irq_n
);

    logic                  clr_pulse;
    logic [EVT_COUNT-1:0]  evt_vec;
    logic [NUM_BRANCH-1:0] branch_q;
    logic [EVT_COUNT-1:0]  evt_q;

    always_comb begin
        evt_vec           = '0;
        evt_vec[EVT_PWON] = por_evt;
        evt_vec[EVT_WAKE] = wake_evt;
        evt_vec[EVT_SPI]  = spi_err;
        evt_vec[EVT_CMD]  = cmd_err;
    end

    irq_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn       (csn),
        .reg_sel   (reg_sel),
        .spi_err   (spi_err),
        .clr_pulse (clr_pulse)
    );

    irq_status_bits #(
        .NUM_BRANCH (NUM_BRANCH)
    ) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .branch_err (branch_err),
        .evt        (evt_vec),
        .clr_pulse  (clr_pulse),
        .branch_q   (branch_q),
        .evt_q      (evt_q)
    );

    assign status = {evt_q, branch_q};
    assign irq_n  = ~(|status);

endmodule

// File: rtl/irq_status_reg_chk.sv
module irq_status_reg_chk
    import irq_status_pkg::*;
#(
    parameter int unsigned NUM_BRANCH = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_BRANCH-1:0]           branch_err,
    input logic                            por_evt,
    input logic                            wake_evt,
    input logic                            cmd_err,
    input logic                            csn,
    input logic                            spi_err,
    input logic [NUM_BRANCH+EVT_COUNT-1:0] status,
    input logic                            irq_n
);

    localparam int unsigned TOP = NUM_BRANCH + EVT_COUNT - 1;

    // R2
    branch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[NUM_BRANCH-1:0] == $past(branch_err)));

    // R3
    pwon_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> status[NUM_BRANCH+EVT_PWON]);

    // R3
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> status[NUM_BRANCH+EVT_WAKE]);

    // R3 R6 R8
    spi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_err |=> status[NUM_BRANCH+EVT_SPI]);

    // R3 R8
    cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> status[NUM_BRANCH+EVT_CMD]);

    // R4
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n |-> (status == '0));

    // R9
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csn |=> ((~status[TOP:NUM_BRANCH] & $past(status[TOP:NUM_BRANCH])) == '0));

endmodule

bind irq_status_reg irq_status_reg_chk #(
    .NUM_BRANCH (NUM_BRANCH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .branch_err (branch_err),
    .por_evt    (por_evt),
    .wake_evt   (wake_evt),
    .cmd_err    (cmd_err),
    .csn        (csn),
    .spi_err    (spi_err),
    .status     (status),
    .irq_n      (irq_n)
);

// File: tb/irq_status_reg_bench.sv
module irq_status_reg_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] branch_err = '0;
    logic       por_evt = 1'b0, wake_evt = 1'b0, cmd_err = 1'b0;
    logic       csn = 1'b1, reg_sel = 1'b0, spi_err = 1'b0;
    logic [7:0] status;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state: 0 idle, 1 other, 2 addressed, 3 faulted
    logic [7:0] m_status;
    int         m_fs;

    irq_status_reg u_irq_status_reg (
        .clk(clk), .rst_n(rst_n), .branch_err(branch_err),
        .por_evt(por_evt), .wake_evt(wake_evt), .cmd_err(cmd_err),
        .csn(csn), .reg_sel(reg_sel), .spi_err(spi_err),
        .status(status), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int next_fs(int fs, logic c, logic s, logic e);
        if (c) return 0;
        if (fs == 3 || e) return 3;
        if (fs == 2 || s) return 2;
        return 1;
    endfunction

    function automatic logic [7:0] next_status(logic [7:0] st, int fs, logic [3:0] br,
                                               logic p, logic w, logic e, logic c,
                                               logic cs);
        logic       clr;
        logic [3:0] ev;
        clr = (fs == 2) && cs && !e;
        ev  = {c, e, w, p} | (st[7:4] & ~{4{clr}});
        return {ev, br};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(logic [3:0] br, logic c, logic s, logic e,
                        logic p, logic w, logic cm);
        branch_err = br; csn = c; reg_sel = s; spi_err = e;
        por_evt = p; wake_evt = w; cmd_err = cm;
        @(posedge clk);
        m_status = next_status(m_status, m_fs, br, p, w, e, cm, c);
        m_fs     = next_fs(m_fs, c, s, e);
        @(negedge clk);
        check("R2 branch bits", status[3:0], m_status[3:0]);
        check("R3/R5/R6/R7/R8 event bits", status[7:4], m_status[7:4]);
        check("R4 irq_n", irq_n, (m_status == 8'h00));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_status = 8'h10;
        m_fs = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 reset status", status, 8'h10);
        check("R1 reset irq_n", irq_n, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release status", status, 8'h10);

        // R5 clean read clears events, R2 branch bit survives the read
        step(4'b0100, 1, 0, 0, 0, 0, 0);
        step(4'b0100, 0, 1, 0, 0, 0, 0);
        step(4'b0100, 0, 0, 0, 0, 0, 0);
        step(4'b0100, 1, 0, 0, 0, 0, 0);
        check("R5 clean read", status, 8'h04);
        check("R2 branch kept over read", status[2], 1'b1);
        step(4'b0000, 1, 0, 0, 0, 0, 0);
        check("R4 irq released", irq_n, 1'b1);

        // R3 wake-up, then R6 faulted frame
        step(4'b0000, 1, 0, 0, 0, 1, 0);
        check("R3 wake bit", status, 8'h20);
        step(4'b0000, 0, 1, 0, 0, 0, 0);
        step(4'b0000, 0, 0, 1, 0, 0, 0);
        step(4'b0000, 1, 0, 0, 0, 0, 0);
        check("R6 faulted frame keeps bits", status, 8'h60);

        // R6 error in the closing cycle
        step(4'b0000, 0, 1, 0, 0, 0, 0);
        step(4'b0000, 1, 0, 1, 0, 0, 0);
        check("R6 error on close", status, 8'h60);

        // R7 unaddressed frame
        step(4'b0000, 0, 0, 0, 0, 0, 0);
        step(4'b0000, 0, 0, 0, 0, 0, 0);
        step(4'b0000, 1, 0, 0, 0, 0, 0);
        check("R7 unaddressed frame", status, 8'h60);

        // R8 event coinciding with the clear
        step(4'b0000, 0, 1, 0, 0, 0, 0);
        step(4'b0000, 1, 0, 0, 0, 0, 1);
        check("R8 event beats clear", status, 8'h80);
        check("R4 irq low", irq_n, 1'b0);
        step(4'b0000, 0, 1, 0, 0, 0, 0);
        step(4'b0000, 1, 0, 0, 0, 0, 0);
        check("R5 second read", status, 8'h00);

        // random traffic, R9 holds across frames
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] br;
            logic       c;
            br = branch_err;
            if ($urandom_range(0, 7) == 0) br = 4'($urandom);
            c = csn;
            if ($urandom_range(0, 4) == 0) c = ~c;
            step(br, c, ($urandom_range(0, 2) == 0), ($urandom_range(0, 24) == 0),
                 ($urandom_range(0, 40) == 0), ($urandom_range(0, 20) == 0),
                 ($urandom_range(0, 20) == 0));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule